// File: doc/BRIEF.md
# Microcoded Two-Byte-Fetch CPU Core

This block is a small processor whose control comes from a microprogram held in a state register and a decoded control word. It holds a file of eight 16-bit registers. The top register acts as the program counter and the one below it is a scratch register that the microcode uses for staging. A single adder-based ALU, an instruction register and a memory address register connect to a byte-wide memory port. That port has a read strobe and a wait input.

Each instruction is 16 bits wide and arrives as two bytes, low byte first. The fetch takes four microsteps. The two read steps can be stretched by the memory holding wait high. When the high byte is accepted, the sequencer jumps straight to the microsequence selected by the 6-bit opcode in that byte. The core executes a register add and a branch-if-zero. The zero test adds all ones to the tested register and reads the carry out. Any other opcode returns directly to the fetch.

Top module: `ucode_cpu16`

## Requirements
- R1: While `rst` is high at a rising edge, the core returns to fetch step 0, clears the program counter and the memory address register, and loads general registers 0 to 6 from `REG_INIT` (register n at bits 16n+15:16n). In the first cycle after release `mem_rd` is low. In the cycle after that, `mem_rd` is high with `mem_addr` = 0.
- R2: Every instruction is read as two accepted byte reads. The first is at PC and supplies instruction bits 7:0. The second is at PC+1 and supplies bits 15:8. The PC then points at PC+2.
- R3: Instruction fields are decoded as follows: opcode in bits 15:10, destination/tested register index in bits 9:8, first source in bits 7:6, second source in bits 5:4, and a signed 8-bit offset in bits 7:0.
- R4: While `mem_wait` is high during a read step, `mem_rd` stays high and `mem_addr` stays unchanged. The step repeats, and the PC still advances by exactly one per accepted byte.
- R5: Opcode 1 writes (first source + second source) mod 2^16 into the destination. The next instruction's first read comes 5 cycles after this instruction's first read when there are no stalls.
- R6: Opcode 3 with a nonzero tested register falls through to the next instruction, 5 cycles after its own first read.
- R7: Opcode 3 with a zero tested register sets PC to (address after the instruction) + sign-extended offset. The next first read comes 6 cycles after its own first read.
- R8: Any opcode other than 1 and 3 changes no register and leads to the next sequential instruction 4 cycles after its own first read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | DW | Byte address from the memory address register |
| mem_rd | output | 1 | Read strobe, high during the two read microsteps |
| mem_rdata | input | BW | Byte returned by memory, captured when wait is low |
| mem_wait | input | 1 | Memory not ready; holds the current read step |

## Verification
The bench runs a short program that visits the branch target twice, once with the tested register nonzero and once after an add has wrapped it to zero. A sequencer that always branched, or that tested the wrong register field, would send the fetch trace to the wrong addresses. The program includes a negative offset that lands earlier in memory, so a zero-extended offset would jump forward instead. An undefined opcode sits between an add that zeroes a register and a branch on that register: a core that let the unknown opcode write would turn the later branch into a fall-through. Stalls of several cycles on both fetch bytes check that a core which let the repeated PC write run ahead would fetch the next instruction from the wrong address.

// File: rtl/cpu16_pkg.sv
`timescale 1ns/1ps
package cpu16_pkg;

  typedef enum logic [1:0] {ALU_AND, ALU_ADD, ALU_INC, ALU_DEC} alu_op_e;

  // register selectors resolved to indices in the top
  typedef enum logic [2:0] {RS_PC, RS_TMP, RS_RI, RS_RJ, RS_RK} rsrc_e;

  typedef enum logic [2:0] {
    ST_F0, ST_F1, ST_F2, ST_F3, ST_ADD, ST_BZ, ST_BR
  } ustate_e;

  // how the next microstep is chosen
  typedef enum logic [1:0] {NX_GO, NX_STALL, NX_DISP, NX_ZTEST} nxt_e;

  typedef struct packed {
    alu_op_e alu;
    rsrc_e   a_src;
    rsrc_e   b_src;
    logic    cin;
    logic    we;
    rsrc_e   w_src;
    logic    w_imm;
    logic    mar_ld;
    logic    rd;
    logic    ir_lo;
    logic    ir_hi;
    nxt_e    nxt;
    ustate_e next;
  } uword_t;

  localparam logic [5:0] OPC_ADD = 6'd1;
  localparam logic [5:0] OPC_BZ  = 6'd3;

  function automatic uword_t ucode(ustate_e s);
    uword_t u;
    u = '0;
    u.alu = ALU_AND;
    u.a_src = RS_PC;
    u.b_src = RS_PC;
    u.w_src = RS_PC;
    u.nxt = NX_GO;
    u.next = ST_F0;
    case (s)
      ST_F0, ST_F2: begin
        // copy PC to scratch and to the address register
        u.alu = ALU_AND;
        u.we = 1'b1;
        u.w_src = RS_TMP;
        u.mar_ld = 1'b1;
        u.next = (s == ST_F0) ? ST_F1 : ST_F3;
      end
      ST_F1, ST_F3: begin
        // PC <= scratch + 1, read the byte
        u.alu = ALU_INC;
        u.a_src = RS_TMP;
        u.cin = 1'b1;
        u.we = 1'b1;
        u.w_src = RS_PC;
        u.rd = 1'b1;
        u.ir_lo = (s == ST_F1);
        u.ir_hi = (s == ST_F3);
        u.nxt = (s == ST_F1) ? NX_STALL : NX_DISP;
        u.next = ST_F2;
      end
      ST_ADD: begin
        u.alu = ALU_ADD;
        u.a_src = RS_RJ;
        u.b_src = RS_RK;
        u.we = 1'b1;
        u.w_src = RS_RI;
      end
      ST_BZ: begin
        // decrement for carry; stage offset in scratch
        u.alu = ALU_DEC;
        u.a_src = RS_RI;
        u.we = 1'b1;
        u.w_src = RS_TMP;
        u.w_imm = 1'b1;
        u.nxt = NX_ZTEST;
      end
      ST_BR: begin
        u.alu = ALU_ADD;
        u.a_src = RS_PC;
        u.b_src = RS_TMP;
        u.we = 1'b1;
        u.w_src = RS_PC;
      end
      default: u.next = ST_F0;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/cpu16_alu.sv
`timescale 1ns/1ps
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] y,
  output logic          cout
);

  logic [DW:0] sum;

  always_comb begin
    unique case (op)
      ALU_AND: sum = {1'b0, a & b};
      ALU_ADD: sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
      ALU_INC: sum = {1'b0, a} + {{DW{1'b0}}, cin};
      ALU_DEC: sum = {1'b0, a} + {1'b0, {DW{1'b1}}};
      default: sum = '0;
    endcase
  end

  assign y    = sum[DW-1:0];
  assign cout = sum[DW];

  // R6/R7: adding all ones carries exactly when the operand is nonzero
  always_comb begin
    if (op == ALU_DEC) begin
      p_dec_carry_r6: assert (cout == (a != '0))
        else $error("decrement carry does not match operand zero test");
    end
  end

endmodule

// File: rtl/cpu16_regfile.sv
`timescale 1ns/1ps
module cpu16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter logic [NREG*DW-1:0] REG_INIT = '0,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ra_idx,
  input  logic [RW-1:0] rb_idx,
  output logic [DW-1:0] ra,
  output logic [DW-1:0] rb,
  input  logic          we,
  input  logic [RW-1:0] w_idx,
  input  logic [DW-1:0] wd
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        // the top register is the program counter and starts at zero
        regs[i] <= (i == NREG - 1) ? '0 : REG_INIT[i*DW +: DW];
      end
    end else if (we) begin
      regs[w_idx] <= wd;
    end
  end

  assign ra = regs[ra_idx];
  assign rb = regs[rb_idx];

endmodule

// File: rtl/cpu16_useq.sv
`timescale 1ns/1ps
module cpu16_useq
  import cpu16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mem_wait,
  input  logic [5:0] opcode,
  input  logic       alu_cout,
  output ustate_e    state,
  output uword_t     uw
);

  ustate_e nxt;

  function automatic ustate_e dispatch(logic [5:0] op);
    ustate_e d;
    case (op)
      OPC_ADD: d = ST_ADD;
      OPC_BZ:  d = ST_BZ;
      default: d = ST_F0;
    endcase
    return d;
  endfunction

  assign uw = ucode(state);

  always_comb begin
    nxt = uw.next;
    unique case (uw.nxt)
      NX_GO:    nxt = uw.next;
      NX_STALL: nxt = mem_wait ? state : uw.next;
      NX_DISP:  nxt = mem_wait ? state : dispatch(opcode);
      NX_ZTEST: nxt = alu_cout ? ST_F0 : ST_BR;
      default:  nxt = ST_F0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_F0;
    else     state <= nxt;
  end

  // R4: a read step repeats while memory is not ready
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (uw.rd && mem_wait) |=> (state == $past(state)))
    else $error("read step left while wait was high");

  // R8: unknown opcode goes straight back to fetch
  p_undef_return_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_F3 && !mem_wait && opcode != OPC_ADD && opcode != OPC_BZ)
      |=> (state == ST_F0))
    else $error("undefined opcode did not return to fetch");

  // R7: zero operand (no carry) leads to the branch step
  p_taken_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BZ && !alu_cout) |=> (state == ST_BR))
    else $error("zero operand did not take the branch");

endmodule

// File: rtl/ucode_cpu16.sv
`timescale 1ns/1ps
module ucode_cpu16
  import cpu16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int BW   = 8,
  parameter int NREG = 8,
  parameter logic [NREG*DW-1:0] REG_INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [BW-1:0] mem_rdata,
  input  logic          mem_wait
);

  localparam int RW    = $clog2(NREG);
  localparam int IW    = 2 * BW;
  localparam int IMM_W = 8;

  ustate_e       state;
  uword_t        uw;
  logic [IW-1:0] ir;
  logic [DW-1:0] mar;
  logic [DW-1:0] ra, rb, alu_y, wd, imm_sx;
  logic          alu_cout;
  logic [RW-1:0] ra_idx, rb_idx, w_idx;
  logic [1:0]    f_ri, f_rj, f_rk;

  assign f_ri   = ir[9:8];
  assign f_rj   = ir[7:6];
  assign f_rk   = ir[5:4];
  assign imm_sx = {{(DW-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};

  function automatic logic [RW-1:0] pick(rsrc_e s, logic [1:0] ri,
                                         logic [1:0] rj, logic [1:0] rk);
    logic [RW-1:0] r;
    case (s)
      RS_PC:   r = RW'(NREG - 1);
      RS_TMP:  r = RW'(NREG - 2);
      RS_RI:   r = RW'(ri);
      RS_RJ:   r = RW'(rj);
      RS_RK:   r = RW'(rk);
      default: r = RW'(NREG - 1);
    endcase
    return r;
  endfunction

  assign ra_idx = pick(uw.a_src, f_ri, f_rj, f_rk);
  assign rb_idx = pick(uw.b_src, f_ri, f_rj, f_rk);
  assign w_idx  = pick(uw.w_src, f_ri, f_rj, f_rk);
  assign wd     = uw.w_imm ? imm_sx : alu_y;

  cpu16_useq u_seq (
    .clk      (clk),
    .rst      (rst),
    .mem_wait (mem_wait),
    .opcode   (mem_rdata[BW-1 -: 6]),
    .alu_cout (alu_cout),
    .state    (state),
    .uw       (uw)
  );

  cpu16_regfile #(.DW(DW), .NREG(NREG), .REG_INIT(REG_INIT)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .ra_idx (ra_idx),
    .rb_idx (rb_idx),
    .ra     (ra),
    .rb     (rb),
    .we     (uw.we),
    .w_idx  (w_idx),
    .wd     (wd)
  );

  cpu16_alu #(.DW(DW)) u_alu (
    .op   (uw.alu),
    .a    (ra),
    .b    (rb),
    .cin  (uw.cin),
    .y    (alu_y),
    .cout (alu_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      ir  <= '0;
    end else begin
      if (uw.mar_ld) mar <= alu_y;
      if (uw.ir_lo && !mem_wait) ir[BW-1:0]  <= mem_rdata;
      if (uw.ir_hi && !mem_wait) ir[IW-1:BW] <= mem_rdata;
    end
  end

  assign mem_addr = mar;
  assign mem_rd   = uw.rd;

  // R4: a stalled read keeps strobe and address
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_wait) |=> (mem_rd && $stable(mem_addr)))
    else $error("stalled read changed strobe or address");

endmodule

// File: tb/ucode_cpu16_tb_top.sv
`timescale 1ns/1ps
module ucode_cpu16_tb_top;

  localparam real CLK_PERIOD = 20.0;
  localparam int  NSTEP = 13;
  // expected instruction start addresses and cycles to the next start
  localparam int EXP_PC  [NSTEP] = '{0, 2, 8, 10, 12, 14, 16, 18, 52, 4, 6, 8, 26};
  localparam int EXP_GAP [NSTEP] = '{5, 6, 5, 4, 5, 5, 5, 6, 6, 5, 5, 6, 6};
  localparam logic [127:0] INIT = {16'h0, 16'h0, 16'h0, 16'h0,
                                   16'h0001, 16'hFFFB, 16'h0005, 16'h1234};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_wait = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem [64];

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int n_log = 0;
  int log_addr [64];
  int log_cyc  [64];
  string tag [NSTEP];

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  ucode_cpu16 #(.REG_INIT(INIT)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .mem_wait  (mem_wait)
  );

  assign mem_rdata = mem[mem_addr[5:0]];

  always @(posedge clk) cyc <= cyc + 1;

  // record every accepted byte read
  always @(negedge clk) begin
    if (rst) n_log = 0;
    else if (mem_rd && !mem_wait && n_log < 64) begin
      log_addr[n_log] = int'(mem_addr);
      log_cyc[n_log]  = cyc;
      n_log++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put16(input int a, input logic [15:0] w);
    mem[a]     = w[7:0];
    mem[a + 1] = w[15:8];
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    put16(0,  16'h0460); // add R0,R1,R2 -> 0
    put16(2,  16'h0C04); // bz R0,+4
    put16(4,  16'h06A0); // add R2,R2,R2
    put16(6,  16'h0E7F); // bz R2,+127
    put16(8,  16'h0D10); // bz R1,+16
    put16(10, 16'hFC00); // undefined opcode 63
    put16(12, 16'h07F0); // add R3,R3,R3 -> 2
    put16(14, 16'h0F02); // bz R3,+2
    put16(16, 16'h0560); // add R1,R1,R2 -> wraps to 0
    put16(18, 16'h0C20); // bz R0,+32
    put16(26, 16'h0CFE); // bz R0,-2 (self loop)
    put16(52, 16'h0DCE); // bz R1,-50
    tag = '{"R5 add", "R7 fwd", "R3 R6 fall", "R8 undef", "R5 add", "R6 fall",
            "R5 wrap", "R7 R8 kept", "R3 R7 back", "R5 add", "R6 fall",
            "R7 second", "R7 loop"};

    // phase 1: reset state and program trace
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(mem_rd == 1'b0, "R1 rd after release", int'(mem_rd), 0);
    chk(mem_addr == 16'd0, "R1 addr after release", int'(mem_addr), 0);
    @(posedge clk); #1;
    chk(mem_rd == 1'b1, "R1 first read", int'(mem_rd), 1);
    chk(mem_addr == 16'd0, "R1 first addr", int'(mem_addr), 0);
    repeat (90) @(posedge clk);
    #1;
    chk(n_log >= 2 * NSTEP + 2, "R2 read count", n_log, 2 * NSTEP + 2);
    for (int i = 0; i < NSTEP; i++) begin
      chk(log_addr[2*i] == EXP_PC[i], tag[i], log_addr[2*i], EXP_PC[i]);
      chk(log_addr[2*i+1] == EXP_PC[i] + 1, "R2 high byte", log_addr[2*i+1], EXP_PC[i] + 1);
      chk(log_cyc[2*i+2] - log_cyc[2*i] == EXP_GAP[i], tag[i],
          log_cyc[2*i+2] - log_cyc[2*i], EXP_GAP[i]);
    end

    // phase 2: reset from mid-run, then stall both fetch bytes
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    chk(mem_rd == 1'b0, "R1 rd after rerun", int'(mem_rd), 0);
    chk(mem_addr == 16'd0, "R1 addr after rerun", int'(mem_addr), 0);
    @(posedge clk); #1;
    chk(mem_rd == 1'b1 && mem_addr == 16'd0, "R1 rerun first read", int'(mem_addr), 0);
    mem_wait = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk(mem_rd == 1'b1 && mem_addr == 16'd0, "R4 low byte hold", int'(mem_addr), 0);
    end
    mem_wait = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(mem_rd == 1'b1 && mem_addr == 16'd1, "R4 high byte read", int'(mem_addr), 1);
    mem_wait = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      chk(mem_rd == 1'b1 && mem_addr == 16'd1, "R4 high byte hold", int'(mem_addr), 1);
    end
    mem_wait = 1'b0;
    repeat (25) @(posedge clk);
    #1;
    chk(log_addr[0] == 0, "R4 addr 0", log_addr[0], 0);
    chk(log_addr[1] == 1, "R4 addr 1", log_addr[1], 1);
    chk(log_addr[2] == 2, "R4 no PC run-ahead", log_addr[2], 2);
    chk(log_addr[3] == 3, "R4 addr 3", log_addr[3], 3);
    chk(log_addr[4] == 8, "R7 after stall", log_addr[4], 8);
    chk(log_cyc[1] - log_cyc[0] == 4, "R4 byte gap", log_cyc[1] - log_cyc[0], 4);
    chk(log_cyc[2] - log_cyc[0] == 7, "R4 instr gap", log_cyc[2] - log_cyc[0], 7);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule